// File: doc/BRIEF.md
# LED Single-Wire Pattern Expander

This block turns a stream of LED colour bytes into the oversampled symbol stream that drives a single-wire addressable LED chain. Each data bit becomes a group of four symbols at a fixed symbol rate. A one is three high symbols and one low symbol. A zero is one high symbol and three low symbols. At a symbol rate near 3 MHz, a symbol lasts about 333 ns and a data bit about 1.33 µs. That keeps a one's high pulse above 650 ns, a zero's high pulse under 500 ns, and the bit period above 1.25 µs.

The block runs on a fast system clock and moves forward by one symbol on each cycle where the symbol enable `sym_tick` is high. Bytes come in through a valid/ready handshake. A byte is taken only when the 32-symbol pattern register is empty, or when it will empty on the current tick, so symbols do not stop between the bytes of a frame. The producer marks the final byte of a frame with `in_last`. After that byte's pattern has been sent, the line is held low for a programmable number of symbol ticks so that the chain latches its colours. During this hold no byte is taken.

Top module: `led_pattern_expander`

## Requirements
- R1: On each symbol tick, one symbol of the current group leaves on `line_out`. A data bit of 1 gives the symbols 1,1,1,0 in that order. A data bit of 0 gives 1,0,0,0.
- R2: An accepted byte is sent most-significant bit first, as 32 symbols (eight 4-symbol groups).
- R3: `line_out` is a register. It changes only at a clock edge where `sym_tick` is high, and it holds its value at every other edge.
- R4: `in_ready` is high when the pattern register is empty. It is also high when the pattern register holds one symbol and `sym_tick` is high, unless the hold of R6 is due. Bytes sent back to back therefore give one unbroken stream of symbols.
- R5: While no pattern symbols are left, every symbol tick drives `line_out` low.
- R6: After the last symbol of a byte that came with `in_last` high, the block holds `line_out` low for LATCH_TICKS symbol ticks (default 150). During these ticks `busy` is high and `in_ready` is low.
- R7: `in_ready` goes high again, and `busy` goes low, right after the LATCH_TICKS-th tick of the hold.
- R8: A synchronous reset drives `line_out` low, empties the pattern register and cancels any hold. After the reset `in_ready` is high and `busy` is low, and no hold follows the reset.
- R9: A byte offered while `in_ready` is low is not taken. It puts no symbol on the line.
- R10: `busy` is high while pattern symbols are left or a hold is running, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_tick | input | 1 | Symbol-rate enable, one pulse for each output symbol |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| in_data | input | DATA_W | Colour byte, MSB first |
| in_last | input | 1 | The offered byte ends a frame |
| line_out | output | 1 | Serial symbol line to the LED chain |
| busy | output | 1 | Pattern in flight or latch hold running |

## Verification
Each symbol reaches `line_out` at the clock edge of its tick, because the line is a single register. The bench therefore records the line and `busy` 1 ns after every tick edge, before anything else changes. The first symbol of each byte is always high, so the bench finds the start of a pattern from the first recorded one. From that point, the symbols of the byte are due on the next 32 ticks. `busy` must still be high at tick offset 31+LATCH_TICKS-1 and low at offset 31+LATCH_TICKS. `in_ready` depends on the tick input through logic alone. The bench sets `sym_tick` 2 ns after a rising edge and reads `in_ready` at the falling edge, so each handshake decision is made on settled values.

// File: rtl/led_pat_pkg.sv
package led_pat_pkg;
    localparam int SYM_PER_BIT = 4;
    localparam logic [SYM_PER_BIT-1:0] GROUP_ONE  = 4'b1110;
    localparam logic [SYM_PER_BIT-1:0] GROUP_ZERO = 4'b1000;
endpackage

// File: rtl/led_bit_encoder.sv
module led_bit_encoder
    import led_pat_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAT_W = DATA_W * SYM_PER_BIT
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAT_W-1:0]  pattern
);
    // Data bit i fills nibble i, so the MSB lands on the top nibble and leaves first.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign pattern[i*SYM_PER_BIT +: SYM_PER_BIT] = data[i] ? GROUP_ONE : GROUP_ZERO;
    end
endmodule

// File: rtl/led_symbol_shifter.sv
module led_symbol_shifter #(
    parameter int PAT_W = 32,
    localparam int CNT_W = $clog2(PAT_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_tick,
    input  logic             load,
    input  logic [PAT_W-1:0] load_pat,
    output logic             line,
    output logic             empty,
    output logic             ending
);
    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic [CNT_W-1:0] cnt;
        logic             line;
    } shift_state_t;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAT_W);

    shift_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sym_tick) begin
            if (s_q.cnt != '0) begin
                s_d.line = s_q.pat[PAT_W-1];
                s_d.pat  = {s_q.pat[PAT_W-2:0], 1'b0};
                s_d.cnt  = s_q.cnt - 1'b1;
            end else begin
                s_d.line = 1'b0;
            end
        end
        if (load) begin
            s_d.pat = load_pat;
            s_d.cnt = FULL_CNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line   = s_q.line;
    assign empty  = (s_q.cnt == '0);
    assign ending = sym_tick && (s_q.cnt == CNT_W'(1));

    // The first symbol of every group is high.
    assert_group_start_high_R1: assert property (@(posedge clk) disable iff (rst)
        (sym_tick && s_q.cnt != '0 && s_q.cnt[1:0] == 2'd0) |=> s_q.line);
    // The last symbol of every group is low.
    assert_group_end_low_R1: assert property (@(posedge clk) disable iff (rst)
        (sym_tick && s_q.cnt[1:0] == 2'd1) |=> !s_q.line);
    assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !sym_tick |=> $stable(s_q.line));
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
        (sym_tick && s_q.cnt == '0) |=> !s_q.line);
    assert_load_when_free_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> (s_q.cnt == '0 || (sym_tick && s_q.cnt == CNT_W'(1))));
    assert_load_fills_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> s_q.cnt == FULL_CNT);
endmodule

// File: rtl/led_latch_timer.sv
module led_latch_timer #(
    parameter int LATCH_TICKS = 150,
    localparam int HOLD_W = $clog2(LATCH_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_tick,
    input  logic start,
    output logic active
);
    typedef struct packed {
        logic              active;
        logic [HOLD_W-1:0] left;
    } hold_state_t;

    hold_state_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (start) begin
            h_d.active = 1'b1;
            h_d.left   = HOLD_W'(LATCH_TICKS);
        end else if (h_q.active && sym_tick) begin
            if (h_q.left == HOLD_W'(1)) begin
                h_d.active = 1'b0;
                h_d.left   = '0;
            end else begin
                h_d.left = h_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign active = h_q.active;

    assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> !h_q.active);
    assert_hold_count_live_R6: assert property (@(posedge clk) disable iff (rst)
        h_q.active |-> (h_q.left != '0));
    assert_hold_waits_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (h_q.active && !sym_tick) |=> (h_q.active && $stable(h_q.left)));
endmodule

// File: rtl/led_pattern_expander.sv
module led_pattern_expander
    import led_pat_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LATCH_TICKS = 150,
    localparam int PAT_W      = DATA_W * SYM_PER_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              line_out,
    output logic              busy
);
    typedef struct packed {
        logic pend_last;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic [PAT_W-1:0] enc_pat;
    logic             sh_empty;
    logic             sh_ending;
    logic             hold_active;
    logic             accept;
    logic             frame_ending;

    led_bit_encoder #(.DATA_W(DATA_W)) u_enc (
        .data    (in_data),
        .pattern (enc_pat)
    );

    led_symbol_shifter #(.PAT_W(PAT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sym_tick (sym_tick),
        .load     (accept),
        .load_pat (enc_pat),
        .line     (line_out),
        .empty    (sh_empty),
        .ending   (sh_ending)
    );

    led_latch_timer #(.LATCH_TICKS(LATCH_TICKS)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .sym_tick (sym_tick),
        .start    (frame_ending),
        .active   (hold_active)
    );

    assign frame_ending = sh_ending && c_q.pend_last;
    assign in_ready     = !hold_active && (sh_empty || (sh_ending && !c_q.pend_last));
    assign accept       = in_valid && in_ready;
    assign busy         = !sh_empty || hold_active;

    always_comb begin
        c_d = c_q;
        if (accept) begin
            c_d.pend_last = in_last;
        end else if (frame_ending) begin
            c_d.pend_last = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assert_no_ready_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> !in_ready);
    assert_hold_follows_last_R6: assert property (@(posedge clk) disable iff (rst)
        frame_ending |=> (busy && !in_ready && hold_active));
    assert_busy_level_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (in_ready && !hold_active));
    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (!line_out && !busy && in_ready));
endmodule

// File: tb/led_pattern_expander_bench.sv
module led_pattern_expander_bench;
    localparam int LATCH = 150;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       line_out;
    logic       busy;

    int checks = 0;
    int failures = 0;
    int div = 0;
    bit mon_en = 1'b0;
    int rec_n = 0;
    logic rec  [0:2047];
    logic brec [0:2047];

    always #10 clk = ~clk;

    led_pattern_expander u_led_pattern_expander (
        .clk(clk), .rst(rst), .sym_tick(sym_tick), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .line_out(line_out), .busy(busy)
    );

    // Symbol enable: one pulse every four clocks, changed 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        div = (div + 1) % 4;
        sym_tick = (div == 0);
    end

    // Record the line and busy 1 ns after every tick edge.
    always @(posedge clk) begin
        if (mon_en && sym_tick) begin
            #1;
            if (rec_n < 2048) begin
                rec[rec_n]  = line_out;
                brec[rec_n] = busy;
                rec_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!sym_tick);
        end
        #3;
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    function automatic logic exp_sym(input logic [7:0] b, input int k);
        int ph = k % 4;
        if (ph == 0) return 1'b1;
        if (ph == 3) return 1'b0;
        return b[7 - k / 4];
    endfunction

    function automatic int first_one(input int from);
        for (int j = from; j < rec_n; j++) if (rec[j] === 1'b1) return j;
        return -1;
    endfunction

    task automatic check_byte(input string req, input int s, input logic [7:0] b);
        for (int k = 0; k < 32; k++) chk(req, rec[s + k], exp_sym(b, k));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R8 reset line", line_out, 1'b0);
        chk("R8 reset ready", in_ready, 1'b1);
        chk("R8 reset busy", busy, 1'b0);
    endtask

    task automatic t_idle;
        rec_n = 0; mon_en = 1'b1;
        wait_ticks(20);
        for (int j = 0; j < 20; j++) chk("R5 idle low", rec[j], 1'b0);
        chk("R10 idle busy", busy, 1'b0);
        mon_en = 1'b0;
    endtask

    task automatic t_single;
        int s;
        rec_n = 0; mon_en = 1'b1;
        send(8'hA5, 1'b1);
        wait_ticks(32 + LATCH + 20);
        mon_en = 1'b0;
        s = first_one(0);
        chk("R1 start found", s >= 0, 1'b1);
        if (s >= 0) begin
            check_byte("R1 R2 byte A5", s, 8'hA5);
            for (int j = 32; j < 31 + LATCH + 10; j++) chk("R6 hold low", rec[s + j], 1'b0);
            chk("R10 busy in pattern", brec[s + 10], 1'b1);
            chk("R6 busy last hold tick", brec[s + 31 + LATCH - 1], 1'b1);
            chk("R7 busy falls", brec[s + 31 + LATCH], 1'b0);
        end
        @(negedge clk);
        chk("R7 ready back", in_ready, 1'b1);
    endtask

    task automatic t_stream;
        int s;
        rec_n = 0; mon_en = 1'b1;
        send(8'hFF, 1'b0);
        send(8'h00, 1'b0);
        send(8'h3C, 1'b1);
        wait_ticks(96 + LATCH + 10);
        mon_en = 1'b0;
        s = first_one(0);
        chk("R4 start found", s >= 0, 1'b1);
        if (s >= 0) begin
            check_byte("R4 byte FF", s, 8'hFF);
            check_byte("R4 byte 00", s + 32, 8'h00);
            check_byte("R4 byte 3C", s + 64, 8'h3C);
            chk("R10 busy mid stream", brec[s + 50], 1'b1);
            chk("R7 stream busy falls", brec[s + 95 + LATCH], 1'b0);
        end
    endtask

    task automatic t_ignore;
        int s;
        rec_n = 0; mon_en = 1'b1;
        send(8'h81, 1'b1);
        wait_ticks(40);
        @(negedge clk);
        chk("R6 ready low in hold", in_ready, 1'b0);
        chk("R6 busy in hold", busy, 1'b1);
        in_valid = 1'b1; in_data = 8'hFF;
        repeat (30) @(negedge clk);
        in_valid = 1'b0;
        wait_ticks(LATCH + 20);
        mon_en = 1'b0;
        s = first_one(0);
        chk("R9 start found", s >= 0, 1'b1);
        if (s >= 0) begin
            check_byte("R9 byte 81", s, 8'h81);
            chk("R9 nothing after", first_one(s + 32), -1);
        end
        @(negedge clk);
        chk("R9 idle after hold", busy, 1'b0);
    endtask

    task automatic t_stable;
        logic prev;
        logic t;
        int bad = 0;
        send(8'h5A, 1'b0);
        @(negedge clk);
        prev = line_out;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            t = sym_tick;
            @(negedge clk);
            if (!t && line_out !== prev) bad++;
            prev = line_out;
        end
        chk("R3 line moves only on tick", bad, 0);
        wait_ticks(20);
    endtask

    task automatic t_midreset;
        send(8'hFF, 1'b1);
        wait_ticks(5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 mid reset line", line_out, 1'b0);
        chk("R8 mid reset busy", busy, 1'b0);
        chk("R8 mid reset ready", in_ready, 1'b1);
        rec_n = 0; mon_en = 1'b1;
        wait_ticks(12);
        mon_en = 1'b0;
        chk("R8 no pattern after reset", first_one(0), -1);
        chk("R8 no hold after reset", busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_single();
        t_stream();
        t_ignore();
        t_stable();
        t_midreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule